// File: doc/BRIEF.md
# System configuration register controller

A memory-mapped block of control and status words on a 32-bit APB-style peripheral bus with a 4 KB address window and no wait states. It holds a general-purpose configuration word and an LED word whose low byte drives eight LED pins. It also returns three read-only identification words set by parameters, and a lock-status word that combines eight external loop-lock inputs under a software mask.

Its main path is an indirect configuration channel. Software first loads an outgoing data word. It then writes a command word that carries a device index, a function code, a direction bit and a start bit. When start is set, the transaction runs in the same cycle as the command write. It reads from or writes to a small bank of oscillator frequency registers and posts done and error flags in a status word. The next bus read sees that result.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset the command word (0x0A8) reads 0x00100000 and the lock word (0x100) reads 0xFF in bits [31:24], the lock inputs in bits [23:16], and the summary in bit 0. The general word (0x000), LED word (0x004), outgoing data (0x0A4), returned data (0x0A0) and status (0x0AC) read zero.
- R2: The general word and the LED word store all 32 written bits and read them back. led_o always equals bits [7:0] of the LED word.
- R3: Offset 0x00C always reads zero. Offsets 0x010, 0xFF8 and 0xFFC read the parameters INFO_VAL, AUX_ID_VAL and BLK_ID_VAL. Writes to these offsets, and to the returned data (0x0A0) and the status (0x0AC), have no effect.
- R4: A write to the command word stores the written value with bits [19:12], [29:26] and 31 forced to zero, so the stored value is the written value ANDed with 0x43F00FFF. The same write clears the status word unless start is set.
- R5: A command write with start (bit 31) set leaves status = 1, meaning done in bit 0. It leaves status = 3, meaning done plus error in bit 1, when the function code (bits [25:20]) is not 1 or the device index (bits [11:0]) is not below OSC_N (3).
- R6: A valid command with direction bit 30 = 1 copies the outgoing data word into oscillator register [device]. A valid command with bit 30 = 0 copies oscillator register [device] into the returned data word.
- R7: An erroring read command leaves the returned data unchanged. An erroring write command changes no oscillator register.
- R8: In the lock word only bits [31:24] (the mask) can be written. Bits [23:16] show lock_i. Bits [15:1] read zero. Bit 0 is 1 exactly when every loop whose mask bit is set has its lock input high.
- R9: Word offsets outside the map read zero, and writes to them change no register.
- R10: The oscillator registers reset to the parameters OSC_RST, which default to 50000000, 24576000 and 25000000 for devices 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address inside the 4 KB window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data (combinational from paddr_i) |
| lock_i | input | 8 | Per-loop lock status |
| led_o | output | 8 | LED drive, low byte of the LED word |

## Verification
The bench sweeps function codes and device indices across the valid/invalid edge, including device 3 just past the bank and the full-width device 0xFFF. A design with an off-by-one range check or a misdecoded function field would flag the wrong status there, or would write into a neighbouring oscillator. After each failed read it checks that the returned data still holds its earlier value, which catches a design that writes the word anyway. It walks every word offset in the window, reading each one and writing junk to the unmapped ones, which exposes partial address decode and aliasing. It also sweeps all 256 lock patterns against several masks, which catches an inverted mask or a summary built with OR instead of AND.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] OFF_GEN   = 12'h000;
  localparam logic [AW-1:0] OFF_LED   = 12'h004;
  localparam logic [AW-1:0] OFF_ZERO  = 12'h00C;
  localparam logic [AW-1:0] OFF_INFO  = 12'h010;
  localparam logic [AW-1:0] OFF_RDATA = 12'h0A0;
  localparam logic [AW-1:0] OFF_WDATA = 12'h0A4;
  localparam logic [AW-1:0] OFF_CMD   = 12'h0A8;
  localparam logic [AW-1:0] OFF_STAT  = 12'h0AC;
  localparam logic [AW-1:0] OFF_LOCK  = 12'h100;
  localparam logic [AW-1:0] OFF_AUX   = 12'hFF8;
  localparam logic [AW-1:0] OFF_ID    = 12'hFFC;

  // command word fields
  localparam int unsigned CMD_DEV_LSB  = 0;
  localparam int unsigned CMD_DEV_W    = 12;
  localparam int unsigned CMD_FN_LSB   = 20;
  localparam int unsigned CMD_FN_W     = 6;
  localparam int unsigned CMD_DIR_BIT  = 30;
  localparam int unsigned CMD_GO_BIT   = 31;
  localparam logic [DW-1:0] CMD_KEEP   = 32'h43F0_0FFF;
  localparam logic [DW-1:0] CMD_RST    = 32'h0010_0000;
  localparam logic [CMD_FN_W-1:0] FN_OSC = 6'd1;

  localparam int unsigned N_LOOP = 8;

  typedef struct packed {
    logic err;
    logic done;
  } ch_stat_t;
endpackage

// File: rtl/lock_summary.sv
module lock_summary #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] lock_i,
  input  logic [N-1:0] mask_i,
  output logic         all_ok_o
);
  // unmasked loops count as locked
  always_comb all_ok_o = &(lock_i | ~mask_i);
endmodule

// File: rtl/cfg_channel.sv
module cfg_channel import sys_cfg_pkg::*; #(
  parameter int unsigned OSC_N = 3,
  parameter logic [OSC_N-1:0][DW-1:0] OSC_RST = {32'd25000000, 32'd24576000, 32'd50000000}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [DW-1:0] cmd_wdata_i,
  input  logic [DW-1:0] out_data_i,
  output logic [DW-1:0] cmd_o,
  output ch_stat_t      stat_o,
  output logic [DW-1:0] rdata_o
);
  logic [CMD_DEV_W-1:0] dev;
  logic [CMD_FN_W-1:0]  fn;
  logic                 go, dir_wr, ok;
  logic [DW-1:0]        osc_sel;
  logic [OSC_N-1:0][DW-1:0] osc_q;
  logic [DW-1:0]        unused_cmd;

  assign dev    = cmd_wdata_i[CMD_DEV_LSB +: CMD_DEV_W];
  assign fn     = cmd_wdata_i[CMD_FN_LSB +: CMD_FN_W];
  assign go     = cmd_wdata_i[CMD_GO_BIT];
  assign dir_wr = cmd_wdata_i[CMD_DIR_BIT];
  assign ok     = (fn == FN_OSC) && (32'(dev) < OSC_N);
  assign unused_cmd = cmd_wdata_i & ~CMD_KEEP;

  always_comb begin
    osc_sel = '0;
    for (int i = 0; i < int'(OSC_N); i++)
      if (32'(dev) == i) osc_sel = osc_q[i];
  end

  for (genvar g = 0; g < int'(OSC_N); g++) begin : g_osc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) osc_q[g] <= OSC_RST[g];
      else if (cmd_we_i && go && dir_wr && ok && (32'(dev) == g))
        osc_q[g] <= out_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= CMD_RST;
      stat_o  <= '0;
      rdata_o <= '0;
    end else if (cmd_we_i) begin
      cmd_o       <= cmd_wdata_i & CMD_KEEP;
      stat_o.done <= go;
      stat_o.err  <= go && !ok;
      if (go && !dir_wr && ok) rdata_o <= osc_sel;
    end
  end
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs import sys_cfg_pkg::*; #(
  parameter int unsigned OSC_N = 3,
  parameter logic [OSC_N-1:0][DW-1:0] OSC_RST = {32'd25000000, 32'd24576000, 32'd50000000},
  parameter logic [DW-1:0] INFO_VAL   = 32'h0000_0000,
  parameter logic [DW-1:0] AUX_ID_VAL = 32'h0000_0000,
  parameter logic [DW-1:0] BLK_ID_VAL = 32'h0000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          psel_i,
  input  logic          penable_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [DW-1:0] pwdata_i,
  output logic [DW-1:0] prdata_o,
  input  logic [N_LOOP-1:0] lock_i,
  output logic [N_LOOP-1:0] led_o
);
  localparam int unsigned WIW = AW - 2;

  logic [WIW-1:0] widx;
  logic           wr_en;
  logic [DW-1:0]  gen_q, led_q, wdata_q, cmd_q, ch_rdata;
  logic [N_LOOP-1:0] mask_q;
  ch_stat_t       ch_stat;
  logic           lock_ok;
  logic [1:0]     unused_addr;

  assign widx  = paddr_i[AW-1:2];
  assign wr_en = psel_i && penable_i && pwrite_i;
  assign unused_addr = paddr_i[1:0];

  function automatic logic at(input logic [WIW-1:0] w, input logic [AW-1:0] off);
    return w == off[AW-1:2];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q   <= '0;
      led_q   <= '0;
      wdata_q <= '0;
      mask_q  <= '1;
    end else if (wr_en) begin
      if (at(widx, OFF_GEN))   gen_q   <= pwdata_i;
      if (at(widx, OFF_LED))   led_q   <= pwdata_i;
      if (at(widx, OFF_WDATA)) wdata_q <= pwdata_i;
      if (at(widx, OFF_LOCK))  mask_q  <= pwdata_i[DW-1 -: N_LOOP];
    end
  end

  cfg_channel #(.OSC_N(OSC_N), .OSC_RST(OSC_RST)) u_chan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (wr_en && at(widx, OFF_CMD)),
    .cmd_wdata_i (pwdata_i),
    .out_data_i  (wdata_q),
    .cmd_o       (cmd_q),
    .stat_o      (ch_stat),
    .rdata_o     (ch_rdata)
  );

  lock_summary #(.N(N_LOOP)) u_lock (
    .lock_i   (lock_i),
    .mask_i   (mask_q),
    .all_ok_o (lock_ok)
  );

  always_comb begin
    prdata_o = '0;
    if      (at(widx, OFF_GEN))   prdata_o = gen_q;
    else if (at(widx, OFF_LED))   prdata_o = led_q;
    else if (at(widx, OFF_INFO))  prdata_o = INFO_VAL;
    else if (at(widx, OFF_RDATA)) prdata_o = ch_rdata;
    else if (at(widx, OFF_WDATA)) prdata_o = wdata_q;
    else if (at(widx, OFF_CMD))   prdata_o = cmd_q;
    else if (at(widx, OFF_STAT))  prdata_o = {30'd0, ch_stat};
    else if (at(widx, OFF_LOCK))  prdata_o = {mask_q, lock_i, 15'd0, lock_ok};
    else if (at(widx, OFF_AUX))   prdata_o = AUX_ID_VAL;
    else if (at(widx, OFF_ID))    prdata_o = BLK_ID_VAL;
  end

  assign led_o = led_q[N_LOOP-1:0];
endmodule

// File: rtl/sys_cfg_regs_chk.sv
module sys_cfg_regs_chk import sys_cfg_pkg::*; #(
  parameter int unsigned OSC_N = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          psel_i,
  input logic          penable_i,
  input logic          pwrite_i,
  input logic [AW-1:0] paddr_i,
  input logic [DW-1:0] pwdata_i,
  input logic [DW-1:0] prdata_o,
  input logic [N_LOOP-1:0] lock_i,
  input logic [N_LOOP-1:0] led_o,
  input ch_stat_t      ch_stat,
  input logic [DW-1:0] ch_rdata
);
  logic wr, cmd_wr, go, bad, mapped;
  assign wr     = psel_i && penable_i && pwrite_i;
  assign cmd_wr = wr && (paddr_i[AW-1:2] == OFF_CMD[AW-1:2]);
  assign go     = pwdata_i[CMD_GO_BIT];
  assign bad    = (pwdata_i[CMD_FN_LSB +: CMD_FN_W] != FN_OSC) ||
                  (32'(pwdata_i[CMD_DEV_LSB +: CMD_DEV_W]) >= OSC_N);

  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < 11; i++) begin
      logic [AW-1:0] o;
      case (i)
        0: o = OFF_GEN;   1: o = OFF_LED;   2: o = OFF_ZERO;  3: o = OFF_INFO;
        4: o = OFF_RDATA; 5: o = OFF_WDATA; 6: o = OFF_CMD;   7: o = OFF_STAT;
        8: o = OFF_LOCK;  9: o = OFF_AUX;   default: o = OFF_ID;
      endcase
      if (paddr_i[AW-1:2] == o[AW-1:2]) mapped = 1'b1;
    end
  end

  p_led_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && paddr_i[AW-1:2] == OFF_LED[AW-1:2]) |=> (led_o == $past(pwdata_i[7:0])));

  p_stat_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !go) |=> (ch_stat == 2'b00));

  p_stat_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && go) |=> (ch_stat.done && (ch_stat.err == $past(bad))));

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && go && bad && !pwdata_i[CMD_DIR_BIT]) |=> $stable(ch_rdata));

  p_lock_view_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i[AW-1:2] == OFF_LOCK[AW-1:2]) |-> (prdata_o[23:16] == lock_i && prdata_o[15:1] == '0));

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (prdata_o == '0));

  p_zero_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i[AW-1:2] == OFF_ZERO[AW-1:2]) |-> (prdata_o == '0));
endmodule

bind sys_cfg_regs sys_cfg_regs_chk #(.OSC_N(OSC_N)) u_chk (.*);

// File: tb/sys_cfg_regs_tb.sv
`timescale 1ns/1ps
module sys_cfg_regs_tb;
  localparam logic [31:0] INFO = 32'hC0FF_0004;
  localparam logic [31:0] AUX  = 32'h1234_5678;
  localparam logic [31:0] BID  = 32'h8765_4321;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, pen = 0, pwr = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [7:0] lock = 8'hFF, led;
  int checks = 0, fails = 0;
  logic [31:0] exp_osc [3];
  logic [31:0] exp_rtn;

  always #2.5 clk = ~clk;

  sys_cfg_regs #(.INFO_VAL(INFO), .AUX_ID_VAL(AUX), .BLK_ID_VAL(BID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .lock_i(lock), .led_o(led));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwr = 1; paddr = a; pwdata = d; pen = 0;
    @(negedge clk); pen = 1;
    @(negedge clk); psel = 0; pen = 0; pwr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwr = 0; paddr = a; pen = 0;
    @(negedge clk); pen = 1; #1 d = prdata;
    @(negedge clk); psel = 0; pen = 0;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic is_mapped(input logic [11:0] a);
    case (a)
      12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0, 12'h0A4,
      12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] lock_word(input logic [7:0] m, input logic [7:0] l);
    logic s = 1'b1;
    for (int i = 0; i < 8; i++) if (m[i] && !l[i]) s = 1'b0;
    return {m, l, 15'd0, s};
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    exp_osc[0] = 32'd50000000; exp_osc[1] = 32'd24576000; exp_osc[2] = 32'd25000000;
    exp_rtn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rchk("R1 cmd", 12'h0A8, 32'h0010_0000);
    rchk("R1 lock", 12'h100, lock_word(8'hFF, 8'hFF));
    rchk("R1 gen", 12'h000, 0);
    rchk("R1 led", 12'h004, 0);
    rchk("R1 wdata", 12'h0A4, 0);
    rchk("R1 rdata", 12'h0A0, 0);
    rchk("R1 stat", 12'h0AC, 0);
    chk("R1 led_o", {24'd0, led}, 0);

    // R10 oscillator reset values via channel reads
    for (int d = 0; d < 3; d++) begin
      wr(12'h0A8, 32'h8010_0000 | d);
      rchk("R10 osc reset", 12'h0A0, exp_osc[d]);
    end
    exp_rtn = exp_osc[2];

    // R2 general and LED words
    foreach (v[i]) begin
      logic [31:0] p = 32'h1 << i ^ 32'hA5C3_0F96;
      wr(12'h004, p);
      #1 chk("R2 led_o", {24'd0, led}, {24'd0, p[7:0]});
      rchk("R2 led word", 12'h004, p);
      wr(12'h000, ~p);
      rchk("R2 gen word", 12'h000, ~p);
    end

    // R3 read-only words
    wr(12'h00C, 32'hFFFF_FFFF); wr(12'h010, 0); wr(12'hFF8, 0); wr(12'hFFC, 0);
    wr(12'h0A0, 32'hDEAD_BEEF); wr(12'h0AC, 32'h3);
    rchk("R3 zero word", 12'h00C, 0);
    rchk("R3 info", 12'h010, INFO);
    rchk("R3 aux id", 12'hFF8, AUX);
    rchk("R3 block id", 12'hFFC, BID);
    rchk("R3 rdata not writable", 12'h0A0, exp_rtn);
    rchk("R3 stat not writable", 12'h0AC, 1);

    // R4..R7 sweep of function codes and devices
    for (int f = 0; f < 4; f++) begin
      for (int di = 0; di < 6; di++) begin
        logic [11:0] dev = (di == 5) ? 12'hFFF : 12'(di);
        logic [5:0] fn = (f == 3) ? 6'h3F : 6'(f);
        logic good = (fn == 6'd1) && (dev < 3);
        logic [31:0] val = 32'h5000_0000 + (f << 8) + di;
        logic [31:0] cw = 32'hC000_0000 | (32'(fn) << 20) | 32'h3C0F_F000 | 32'(dev);
        wr(12'h0A4, val);
        wr(12'h0A8, cw);
        if (good) exp_osc[dev] = val;
        rchk("R4 cmd masked", 12'h0A8, cw & 32'h43F0_0FFF);
        rchk("R5 write status", 12'h0AC, good ? 1 : 3);
        wr(12'h0A8, cw & ~32'h4000_0000);
        if (good) exp_rtn = exp_osc[dev];
        rchk("R5 read status", 12'h0AC, good ? 1 : 3);
        rchk(good ? "R6 read back" : "R7 rdata held", 12'h0A0, exp_rtn);
        wr(12'h0A8, cw & 32'h7FFF_FFFF);
        rchk("R4 status cleared", 12'h0AC, 0);
      end
    end
    for (int d = 0; d < 3; d++) begin
      wr(12'h0A8, 32'h8010_0000 | d);
      rchk("R7 osc bank", 12'h0A0, exp_osc[d]);
    end

    // R8 lock word
    wr(12'h100, 32'h00FF_FFFF);
    rchk("R8 only mask writable", 12'h100, lock_word(8'h00, lock));
    for (int mi = 0; mi < 11; mi++) begin
      logic [7:0] m = (mi < 8) ? 8'(1 << mi) : (mi == 8 ? 8'h00 : (mi == 9 ? 8'hFF : 8'h5A));
      wr(12'h100, {m, 24'h0});
      for (int l = 0; l < 256; l++) begin
        @(negedge clk); lock = 8'(l); paddr = 12'h100;
        #1 chk("R8 lock word", prdata, lock_word(m, 8'(l)));
      end
    end
    lock = 8'hFF;

    // R9 unmapped offsets
    wr(12'h000, 32'h1111_1111); wr(12'h004, 32'h2222_2222); wr(12'h0A4, 32'h3333_3333);
    wr(12'h100, 32'h4400_0000);
    for (int a = 0; a < 4096; a += 4) begin
      if (!is_mapped(12'(a))) begin
        @(negedge clk); paddr = 12'(a);
        #1 chk("R9 unmapped read", prdata, 0);
        wr(12'(a), 32'hFFFF_FFFF);
      end
    end
    rchk("R9 gen intact", 12'h000, 32'h1111_1111);
    rchk("R9 led intact", 12'h004, 32'h2222_2222);
    rchk("R9 wdata intact", 12'h0A4, 32'h3333_3333);
    rchk("R9 cmd intact", 12'h0A8, 32'h0010_0002);
    rchk("R9 lock intact", 12'h100, lock_word(8'h44, 8'hFF));
    rchk("R9 stat intact", 12'h0AC, 1);
    for (int d = 0; d < 3; d++) begin
      wr(12'h0A8, 32'h8010_0000 | d);
      rchk("R9 osc intact", 12'h0A0, exp_osc[d]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule